// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

This block is a small, synthesizable model of a synchronous static memory with registered inputs and a registered read path. All synchronous controls are sampled on the rising clock edge: address, write data, chip select, two address strobes, a burst advance input and the write controls. Two strobes can start an access. A processor-side strobe always starts with a read, even when write controls are present. A controller-side strobe honours the write controls in its first cycle.

After an access starts, the block needs no further strobe to keep going. Each later cycle uses an internal two-bit burst counter that steps when advance is low and holds when it is high. The counter runs in linear or interleaved order, chosen by a mode pin. Writes can cover single bytes under a byte-write qualifier, or the whole word through a global write that overrides the per-byte enables.

Read data is driven one clock after the address is captured, which gives a 3-1-1-1 burst pattern. The output drive enable follows the asynchronous output enable and the asynchronous sleep input. It also drops in the cycle after any write is captured, whatever the output enable says.

Top module: `psb_sram`

## Requirements
- R1: While reset is held, `dq_oe` is 0 and `dq_out` is all zeros.
- R2: An access starts only on an edge where `strb_cpu_n` or `strb_ctl_n` is low. While no access is active, write controls sampled without a strobe leave the memory unchanged.
- R3: A read captured at edge E updates `dq_out` at edge E+1 and is driven (`dq_oe` = 1 with `oe_n` low) until edge E+2.
- R4: A write started by `strb_ctl_n` with `gwr_n` high writes lane i (bits `[8i+7:8i]`) only when `bwr_n` is low and `bsel_n[i]` is low. With `bwr_n` high, no lane is written.
- R5: With `gwr_n` low, a write stores all four lanes whatever `bwr_n` and `bsel_n` are.
- R6: On the edge where `strb_cpu_n` is low with the chip selected, `gwr_n`, `bwr_n` and `bsel_n` are ignored and the cycle is a read.
- R7: In cycles after the start, `adv_n` low steps the burst count before use and `adv_n` high holds it. The low two address bits are base + count mod 4 when `lin_mode` is 1, and base XOR count when `lin_mode` is 0. The upper bits are kept.
- R8: `dq_oe` is 0 in the cycle following an edge that captures a write, even with `oe_n` low.
- R9: `oe_n` acts asynchronously: while it is high, `dq_oe` is 0 at once.
- R10: A strobe with `cs_n` high ends the access. After the next edge `dq_oe` is 0 and `dq_out` keeps the last read word.
- R11: While `sleep` is high, `dq_oe` is 0 and all synchronous inputs are ignored, including writes. Sleep may only be entered while deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, low active, sampled with a strobe |
| strb_cpu_n | input | 1 | Processor-side address strobe, low active |
| strb_ctl_n | input | 1 | Controller-side address strobe, low active |
| adv_n | input | 1 | Burst advance, low steps the counter |
| gwr_n | input | 1 | Global write, low writes every lane |
| bwr_n | input | 1 | Byte-write qualifier, low active |
| bsel_n | input | BYTES | Per-lane write enables, low active |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| din | input | BYTES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, low active |
| sleep | input | 1 | Asynchronous sleep request |
| dq_out | output | BYTES*LANE_W | Output data register |
| dq_oe | output | 1 | Output drive enable (1 drives, 0 high impedance) |

## Verification
On every cycle, the assertions check the drive-enable rules: disabled when output enable is high, disabled during sleep, disabled after a captured write, and disabled after a deselect with the output register unchanged. The scenarios carry the content-level behaviour: byte-lane merging, the global-write override, write controls ignored on processor-strobe starts, linear and interleaved burst order with wrap and suspend, and writes ignored with no strobe or during sleep. A monitor checks each of these against a scoreboard of expected read words, each due two edges after its read was driven.

// File: rtl/psb_pkg.sv
package psb_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/psb_burst_gen.sv
// Burst address generator: holds the start address and a small counter,
// produces the address used by the current cycle.
module psb_burst_gen #(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              load,
   input  logic              sel,
   input  logic              adv_n,
   input  logic              lin,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              active,
   output logic [ADDR_W-1:0] addr_eff
);
   logic [ADDR_W-1:0] base_q, base_sel;
   logic [CNT_W-1:0]  cnt_q, cnt_nx, low;
   logic              act_q;

   always_comb begin
      cnt_nx = cnt_q;
      if (load)
         cnt_nx = '0;
      else if (act_q && !adv_n)
         cnt_nx = cnt_q + CNT_W'(1);
   end

   assign base_sel = load ? addr_in : base_q;
   assign low      = lin ? (base_sel[CNT_W-1:0] + cnt_nx)
                         : (base_sel[CNT_W-1:0] ^ cnt_nx);
   assign addr_eff = {base_sel[ADDR_W-1:CNT_W], low};
   assign active   = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
      end else if (!hold) begin
         if (load) begin
            base_q <= addr_in;
            act_q  <= sel;
         end
         cnt_q <= cnt_nx;
      end
   end
endmodule

// File: rtl/psb_wr_dec.sv
// Combines global write, byte-write qualifier and per-lane enables.
module psb_wr_dec #(
   parameter int BYTES = 4
) (
   input  logic             gwr_n,
   input  logic             bwr_n,
   input  logic [BYTES-1:0] bsel_n,
   output logic [BYTES-1:0] mask,
   output logic             wr_det
);
   always_comb begin
      if (!gwr_n)
         mask = '1;
      else if (!bwr_n)
         mask = ~bsel_n;
      else
         mask = '0;
   end
   assign wr_det = |mask;
endmodule

// File: rtl/psb_lane.sv
// One byte lane of storage with registered-address read.
module psb_lane #(
   parameter int ADDR_W = 6,
   parameter int W      = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   output logic [W-1:0]      rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[addr] <= wdata;
   end
   assign rdata = mem[addr];
endmodule

// File: rtl/psb_sram.sv
module psb_sram #(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 4,
   parameter int LANE_W = 8,
   parameter int CNT_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_n,
   input  logic                    strb_cpu_n,
   input  logic                    strb_ctl_n,
   input  logic                    adv_n,
   input  logic                    gwr_n,
   input  logic                    bwr_n,
   input  logic [BYTES-1:0]        bsel_n,
   input  logic                    lin_mode,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [BYTES*LANE_W-1:0] din,
   input  logic                    oe_n,
   input  logic                    sleep,
   output logic [BYTES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);
   import psb_pkg::*;
   localparam int DW = BYTES * LANE_W;

   generate
      if (BYTES < 1 || LANE_W < 1 || CNT_W < 1 || ADDR_W <= CNT_W)
         $error("psb_sram: illegal parameter set");
   endgenerate

   logic              load, active, wr_det;
   logic [ADDR_W-1:0] addr_eff, addr_q;
   logic [BYTES-1:0]  mask, mask_q;
   logic [DW-1:0]     din_q, rd_word, dout_q;
   op_e               op_nx, op_q;
   logic              vld_q;

   assign load = !sleep && (!strb_cpu_n || !strb_ctl_n);

   psb_burst_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (sleep),
      .load     (load),
      .sel      (!cs_n),
      .adv_n    (adv_n),
      .lin      (lin_mode),
      .addr_in  (addr),
      .active   (active),
      .addr_eff (addr_eff)
   );

   psb_wr_dec #(.BYTES(BYTES)) u_wdec (
      .gwr_n  (gwr_n),
      .bwr_n  (bwr_n),
      .bsel_n (bsel_n),
      .mask   (mask),
      .wr_det (wr_det)
   );

   // command decode for the edge about to come
   always_comb begin
      op_nx = OP_IDLE;
      if (!sleep) begin
         if (load) begin
            if (!cs_n)
               op_nx = !strb_cpu_n ? OP_READ : (wr_det ? OP_WRITE : OP_READ);
         end else if (active) begin
            op_nx = wr_det ? OP_WRITE : OP_READ;
         end
      end
   end

   // input register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         addr_q <= '0;
         mask_q <= '0;
         din_q  <= '0;
      end else begin
         op_q   <= op_nx;
         addr_q <= addr_eff;
         mask_q <= mask;
         din_q  <= din;
      end
   end

   // storage, one instance per byte lane
   generate
      for (genvar g = 0; g < BYTES; g++) begin : g_lane
         psb_lane #(.ADDR_W(ADDR_W), .W(LANE_W)) u_lane (
            .clk   (clk),
            .we    (op_q == OP_WRITE && mask_q[g]),
            .addr  (addr_q),
            .wdata (din_q[g*LANE_W +: LANE_W]),
            .rdata (rd_word[g*LANE_W +: LANE_W])
         );
      end
   endgenerate

   // output register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         if (op_q == OP_READ)
            dout_q <= rd_word;
         vld_q <= (op_q == OP_READ);
      end
   end

   assign dq_out = dout_q;
   assign dq_oe  = !oe_n && !sleep && vld_q && (op_q != OP_WRITE);
endmodule

// File: rtl/psb_sram_chk.sv
module psb_sram_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          strb_cpu_n,
   input logic          strb_ctl_n,
   input logic          gwr_n,
   input logic          oe_n,
   input logic          sleep,
   input logic [DW-1:0] dq_out,
   input logic          dq_oe
);
   // R8: a captured global write forces high impedance in the next cycle
   p_write_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !cs_n && !strb_ctl_n && strb_cpu_n && !gwr_n) |=> !dq_oe);

   // R9: output enable high never drives
   p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe);

   // R11: sleep never drives
   p_sleep_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dq_oe);

   // R10: deselect releases the outputs after one more edge
   p_desel_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && cs_n && (!strb_cpu_n || !strb_ctl_n)) |=> ##1 !dq_oe);

   // R10: the output register keeps its word across the deselect
   p_desel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && cs_n && (!strb_cpu_n || !strb_ctl_n)) |=> ##1 $stable(dq_out));
endmodule

bind psb_sram psb_sram_chk #(.DW(BYTES*LANE_W)) u_chk (.*);

// File: tb/psb_sram_bench.sv
module psb_sram_bench;
   localparam int AW = 6;
   localparam int NB = 4;
   localparam int LW = 8;
   localparam int DW = NB * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
   logic          gwr_n = 1'b1, bwr_n = 1'b1, lin_mode = 1'b1, oe_n = 1'b0, sleep = 1'b0;
   logic [NB-1:0] bsel_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   always #5 clk = ~clk;

   psb_sram #(.ADDR_W(AW), .BYTES(NB), .LANE_W(LW), .CNT_W(2)) u_psb_sram (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strb_cpu_n(strb_cpu_n),
      .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .gwr_n(gwr_n), .bwr_n(bwr_n),
      .bsel_n(bsel_n), .lin_mode(lin_mode), .addr(addr), .din(din),
      .oe_n(oe_n), .sleep(sleep), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   logic [DW-1:0] mdl [64];
   int            q_due [$];
   logic [DW-1:0] q_exp [$];
   string         q_req [$];
   logic [AW-1:0] b_base = '0;
   int            b_cnt = 0;
   bit            b_lin = 1'b1;
   logic [DW-1:0] last_exp = '0;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: compares due read words at the falling edge
   always @(negedge clk) begin
      while (q_due.size() > 0 && q_due[0] == cyc) begin
         chk(q_req[0], dq_out, q_exp[0]);
         void'(q_due.pop_front());
         void'(q_exp.pop_front());
         void'(q_req.pop_front());
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   function automatic logic [AW-1:0] baddr();
      logic [1:0] lo;
      lo = b_lin ? (b_base[1:0] + 2'(b_cnt)) : (b_base[1:0] ^ 2'(b_cnt));
      return {b_base[AW-1:2], lo};
   endfunction

   task automatic push(input logic [DW-1:0] e, input string req);
      q_due.push_back(cyc + 2);
      q_exp.push_back(e);
      q_req.push_back(req);
      last_exp = e;
   endtask

   task automatic idle_pins();
      cs_n = 1'b0; strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
      gwr_n = 1'b1; bwr_n = 1'b1; bsel_n = '1;
   endtask

   task automatic t_deselect();
      idle_pins();
      cs_n = 1'b1; strb_ctl_n = 1'b0;
      tick();
   endtask

   task automatic t_ctl_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input bit gw, input bit bw, input logic [NB-1:0] bs);
      idle_pins();
      strb_ctl_n = 1'b0; addr = a; din = d;
      gwr_n = !gw; bwr_n = !bw; bsel_n = bs;
      for (int i = 0; i < NB; i++)
         if (gw || (bw && !bs[i]))
            mdl[a][i*LW +: LW] = d[i*LW +: LW];
      b_base = a; b_cnt = 0;
      tick();
   endtask

   task automatic t_cpu_read(input logic [AW-1:0] a, input logic gwn, input logic bwn,
                             input logic [NB-1:0] bs, input string req);
      idle_pins();
      strb_cpu_n = 1'b0; addr = a; din = 32'hDEAD_BEEF;
      gwr_n = gwn; bwr_n = bwn; bsel_n = bs;
      b_base = a; b_cnt = 0;
      push(mdl[a], req);
      tick();
   endtask

   task automatic t_cont(input bit adv, input string req);
      idle_pins();
      adv_n = !adv;
      if (adv) b_cnt = (b_cnt + 1) % 4;
      push(mdl[baddr()], req);
      tick();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 dq_oe", {31'd0, dq_oe}, 32'd0);
      chk("R1 dq_out", dq_out, 32'd0);
      #1 rst_n = 1'b1;
      tick();

      // R5: global write overrides byte controls
      for (int i = 0; i < 8; i++)
         t_ctl_write(AW'(i), 32'h0102_0304 * (i + 1), 1'b1, (i % 2) == 1, 4'b1110);

      // R4: lanes 0 and 2 only; then a write without the qualifier
      t_ctl_write(6'd3, 32'hA5A5_A5A5, 1'b0, 1'b1, 4'b1010);
      t_ctl_write(6'd4, 32'h1234_5678, 1'b0, 1'b0, 4'b0000);

      // R6: processor strobe with write controls active reads instead
      t_cpu_read(6'd3, 1'b0, 1'b0, 4'b0000, "R6 R4");
      // R7: linear burst from 3 wraps to 0,1,2 then holds
      t_cont(1'b1, "R7 linear");
      t_cont(1'b1, "R7 linear");
      t_cont(1'b1, "R7 linear");
      t_cont(1'b0, "R7 hold");
      t_cpu_read(6'd4, 1'b1, 1'b1, 4'b1111, "R3 R4");

      // R7: interleaved burst from 5
      lin_mode = 1'b0; b_lin = 1'b0;
      t_cpu_read(6'd5, 1'b1, 1'b1, 4'b1111, "R7 interleave");
      t_cont(1'b1, "R7 interleave");
      t_cont(1'b1, "R7 interleave");
      t_cont(1'b1, "R7 interleave");
      t_cont(1'b0, "R7 interleave hold");

      // R3 and R9: driven while reading, then gated by oe_n asynchronously
      chk("R3 dq_oe driven", {31'd0, dq_oe}, 32'd1);
      oe_n = 1'b1; #1;
      chk("R9 dq_oe with oe_n high", {31'd0, dq_oe}, 32'd0);
      oe_n = 1'b0; #1;
      chk("R9 dq_oe with oe_n low", {31'd0, dq_oe}, 32'd1);

      // R8: write cycle forces high impedance
      lin_mode = 1'b1; b_lin = 1'b1;
      t_ctl_write(6'd10, 32'hCAFE_F00D, 1'b1, 1'b0, 4'b1111);
      chk("R8 dq_oe after write", {31'd0, dq_oe}, 32'd0);
      t_cpu_read(6'd10, 1'b1, 1'b1, 4'b1111, "R8 readback");

      // R10: deselect in one cycle, output word kept
      t_cont(1'b0, "R10 last read");
      t_deselect();
      chk("R10 still driving", {31'd0, dq_oe}, 32'd1);
      idle_pins(); cs_n = 1'b1;
      tick();
      chk("R10 dq_oe", {31'd0, dq_oe}, 32'd0);
      chk("R10 dq_out held", dq_out, last_exp);

      // R2: write controls without a strobe while idle do nothing
      idle_pins(); gwr_n = 1'b0; addr = 6'd0; din = 32'hFFFF_FFFF;
      tick(); tick(); tick();
      t_cpu_read(6'd0, 1'b1, 1'b1, 4'b1111, "R2");

      // R11: sleep after deselect; writes during sleep ignored
      t_deselect();
      idle_pins(); cs_n = 1'b1;
      tick(); tick();
      sleep = 1'b1; #1;
      chk("R11 dq_oe at sleep", {31'd0, dq_oe}, 32'd0);
      idle_pins(); strb_ctl_n = 1'b0; gwr_n = 1'b0; addr = 6'd1; din = 32'h5555_AAAA;
      tick();
      chk("R11 dq_oe during sleep", {31'd0, dq_oe}, 32'd0);
      idle_pins(); strb_cpu_n = 1'b0; addr = 6'd2;
      tick();
      chk("R11 dq_oe during sleep", {31'd0, dq_oe}, 32'd0);
      idle_pins(); cs_n = 1'b1;
      sleep = 1'b0;
      tick(); tick();
      t_cpu_read(6'd1, 1'b1, 1'b1, 4'b1111, "R11 no write in sleep");

      t_deselect();
      idle_pins(); cs_n = 1'b1;
      repeat (4) tick();
      chk("R3 scoreboard drained", 32'(q_due.size()), 32'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule